// File: doc/BRIEF.md
# Programmable 8-input interrupt controller

This block gathers up to eight interrupt request lines, decides which one the processor should serve, and raises a single interrupt output. Software programs it over an 8-bit write port with one address line. A short initialization sequence sets the trigger style, the vector base and the end-of-service style. After that, run-time command writes change the mask, end a service level, or pick which status register a read returns.

When the processor accepts the interrupt it pulses the acknowledge input for one cycle. In that cycle the read data bus carries the vector, which is the programmed base plus the index of the winning input. The winning request then moves to the in-service register. In automatic mode it does not stay there.

Only single-controller operation is built. When the first word asks for cascading, the controller takes the third word and then ignores its content. Priority is fixed, with input 0 the highest.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset the interrupt output is low and a read at address 0 returns 0x00.
- R2: An address-0 write with bit 4 = 1 starts initialization. Bit 3 selects level (1) or edge (0) triggering, bit 1 selects single (1) or cascaded (0) operation, and bit 0 = 1 announces a fourth word. The base word follows at address 1. A third word at address 1 is taken only in cascaded mode, and the fourth word only when announced. The interrupt output stays low until the sequence completes.
- R3: During an acknowledge pulse, read data equals base + index of the winning input. An acknowledge with the interrupt output low changes no state and returns base + 7.
- R4: An address-1 write after initialization loads the mask, where bit n = 1 masks input n. A masked request never raises the output. A read at address 1 returns the mask.
- R5: Among pending unmasked requests, the lowest index wins.
- R6: The output is high only when the winning pending request has a lower index than every in-service bit.
- R7: In normal mode an acknowledge clears the winner's request bit and sets its in-service bit.
- R8: When bit 1 of the fourth word is 1 (automatic end of service), an acknowledge leaves the in-service register unchanged.
- R9: An address-0 write of 0x20 (bits 7:5 = 001, bits 4:3 = 00) clears the lowest-index in-service bit.
- R10: An address-0 write with bit 4 = 0, bit 3 = 1 and bit 1 = 1 selects what an address-0 read returns: bit 0 = 1 gives the in-service register, 0 gives the request register.
- R11: In edge mode a request bit is set by a rising input. It is not set again while the input stays high.
- R12: In level mode the request bit follows the input, with one clock of delay.
- R13: Writing a new first word clears the mask, the request and in-service registers, and the read selection, and holds the output low until the new sequence completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the command port |
| rd_en | input | 1 | Read strobe for the status port |
| addr | input | 1 | Word select line |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, or the vector during acknowledge |
| ack | input | 1 | One-cycle interrupt acknowledge |
| irq_in | input | 8 | Request inputs, index 0 highest priority |
| int_out | output | 1 | Interrupt request to the processor |

## Verification
The hardest situation to reach from the ports is a nested service. A high-numbered level sits in service while a lower-priority request waits and is held back. A higher-priority request then preempts it, and the two end-of-service commands must unwind the levels in order. The bench builds this in steps. It raises one input and acknowledges it, adds a lower-priority input and checks that it is blocked, then adds a higher-priority input and acknowledges that too. After each step it reads the in-service register through the read-select command. It also stops part-way through a cascaded initialization sequence, with a request pending, to show that the output stays gated.

// File: rtl/irqc_pkg.sv
// Package: shared types and command codes for the interrupt controller.
// Assumes an 8-bit command port; the codes below are fixed by the
// software-visible encoding.
package irqc_pkg;
    // Progress through the initialization sequence.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_W2   = 3'd1,
        ST_W3   = 3'd2,
        ST_W4   = 3'd3,
        ST_RUN  = 3'd4
    } init_st_e;

    // Bits 7:5 of the end-of-service command that clears the top level.
    localparam logic [2:0] OP_EOI_NONSPEC = 3'b001;
endpackage

// File: rtl/irqc_cfg.sv
// Module: irqc_cfg
// Decodes writes on the command port. It steps through the
// initialization words and holds the configuration, the mask and the
// read selection. It also emits one-cycle pulses for a restart and
// for a non-specific end of service.
// Assumes N_IRQ <= DATA_W. Writes in ST_IDLE other than a first word
// are ignored.
module irqc_cfg
    import irqc_pkg::*;
#(
    parameter int N_IRQ  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ready,
    output logic              level,
    output logic              aeoi,
    output logic [DATA_W-1:0] base,
    output logic [N_IRQ-1:0]  mask,
    output logic              rd_isr,
    output logic              restart,
    output logic              eoi_ns
);
    init_st_e state;
    logic     single_q;
    logic     need4_q;
    logic     run_cmd;

    // Decode the pulses that other blocks act on in the same cycle.
    always_comb begin
        restart = wr_en && !addr && wdata[4];
        run_cmd = wr_en && !addr && !wdata[4] && (state == ST_RUN);
        eoi_ns  = run_cmd && !wdata[3] && (wdata[7:5] == OP_EOI_NONSPEC);
        ready   = (state == ST_RUN);
    end

    // Step the sequence and hold the programmed settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            level    <= 1'b0;
            aeoi     <= 1'b0;
            single_q <= 1'b1;
            need4_q  <= 1'b0;
            base     <= '0;
            mask     <= '0;
            rd_isr   <= 1'b0;
        end else if (restart) begin
            level    <= wdata[3];
            single_q <= wdata[1];
            need4_q  <= wdata[0];
            aeoi     <= 1'b0;
            mask     <= '0;
            rd_isr   <= 1'b0;
            state    <= ST_W2;
        end else if (wr_en && addr) begin
            case (state)
                ST_W2: begin
                    base <= wdata;
                    if (!single_q)    state <= ST_W3;
                    else if (need4_q) state <= ST_W4;
                    else              state <= ST_RUN;
                end
                ST_W3:   state <= need4_q ? ST_W4 : ST_RUN;
                ST_W4: begin
                    aeoi  <= wdata[1];
                    state <= ST_RUN;
                end
                ST_RUN:  mask <= wdata[N_IRQ-1:0];
                default: state <= state;
            endcase
        end else if (run_cmd && wdata[3] && wdata[1]) begin
            rd_isr <= wdata[0];
        end
    end
endmodule

// File: rtl/irqc_req.sv
// Module: irqc_req
// Request register. In edge mode a bit is set on a rising input. In
// level mode each bit copies its input. An acknowledge clears the
// chosen bit, and a restart clears them all.
// Assumes the inputs are already synchronous to clk.
module irqc_req #(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level,
    input  logic             clear_all,
    input  logic [N_IRQ-1:0] irq_in,
    input  logic [N_IRQ-1:0] ack_clr,
    output logic [N_IRQ-1:0] irr
);
    logic [N_IRQ-1:0] prev_q;
    logic [N_IRQ-1:0] rise;

    // Rising-edge detect against the previous cycle.
    always_comb rise = irq_in & ~prev_q;

    // Remember last cycle's inputs for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= irq_in;
    end

    // Update the request bits for the selected trigger style.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_all) irr <= '0;
        else if (level)          irr <= irq_in & ~ack_clr;
        else                     irr <= (irr | rise) & ~ack_clr;
    end
endmodule

// File: rtl/irqc_prio.sv
// Module: irqc_prio
// Fixed-priority resolver. It reports whether any bit is set and the
// lowest set index.
// Assumes IDX_W is wide enough to hold N_IRQ-1.
module irqc_prio #(
    parameter int N_IRQ = 8,
    parameter int IDX_W = $clog2(N_IRQ)
) (
    input  logic [N_IRQ-1:0] req,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);
    // Scan from the lowest priority upward so the lowest index wins.
    always_comb begin
        valid = |req;
        idx   = '0;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_ctrl8.sv
// Module: irq_ctrl8
// Top of the interrupt controller. It ties the command decoder, the
// request register and two priority resolvers to the in-service
// register. It forms the interrupt output, and the vector or status
// on the read bus.
// Assumes one-cycle acknowledge pulses, and single-controller
// operation only.
module irq_ctrl8
    import irqc_pkg::*;
#(
    parameter int N_IRQ  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              ack,
    input  logic [N_IRQ-1:0]  irq_in,
    output logic              int_out
);
    localparam int IDX_W = $clog2(N_IRQ);
    localparam logic [N_IRQ-1:0] ONE = N_IRQ'(1);

    logic              cfg_ready, cfg_level, cfg_aeoi, cfg_rd_isr;
    logic              cfg_restart, cfg_eoi;
    logic [DATA_W-1:0] cfg_base;
    logic [N_IRQ-1:0]  mask_q, irr_q, isr_q, isr_n, pend, ack_clr;
    logic              p_val, s_val, take;
    logic [IDX_W-1:0]  p_idx, s_idx;
    logic [DATA_W-1:0] vec;

    irqc_cfg #(.N_IRQ(N_IRQ), .DATA_W(DATA_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .ready   (cfg_ready),
        .level   (cfg_level),
        .aeoi    (cfg_aeoi),
        .base    (cfg_base),
        .mask    (mask_q),
        .rd_isr  (cfg_rd_isr),
        .restart (cfg_restart),
        .eoi_ns  (cfg_eoi)
    );

    irqc_req #(.N_IRQ(N_IRQ)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (cfg_level),
        .clear_all (cfg_restart),
        .irq_in    (irq_in),
        .ack_clr   (ack_clr),
        .irr       (irr_q)
    );

    irqc_prio #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_pend_prio (
        .req   (pend),
        .valid (p_val),
        .idx   (p_idx)
    );

    irqc_prio #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_isr_prio (
        .req   (isr_q),
        .valid (s_val),
        .idx   (s_idx)
    );

    // Decide whether to interrupt and which request an acknowledge takes.
    always_comb begin
        pend    = irr_q & ~mask_q;
        int_out = cfg_ready && p_val && (!s_val || (p_idx < s_idx));
        take    = ack && int_out;
        ack_clr = take ? (ONE << p_idx) : '0;
        vec     = cfg_base + (int_out ? DATA_W'(p_idx) : DATA_W'(N_IRQ - 1));
    end

    // Next in-service value: end-of-service clear, then acknowledge set.
    always_comb begin
        isr_n = isr_q;
        if (cfg_eoi && s_val) isr_n = isr_n & ~(ONE << s_idx);
        if (take && !cfg_aeoi) isr_n = isr_n | ack_clr;
    end

    // Hold the in-service register.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_restart) isr_q <= '0;
        else                       isr_q <= isr_n;
    end

    // Drive the vector during acknowledge, otherwise the selected status.
    always_comb begin
        if (ack)
            rdata = vec;
        else if (rd_en && addr)
            rdata = DATA_W'(mask_q);
        else if (rd_en)
            rdata = cfg_rd_isr ? DATA_W'(isr_q) : DATA_W'(irr_q);
        else
            rdata = '0;
    end
endmodule

// File: rtl/irqc_checker.sv
// Module: irqc_checker
// Temporal properties of the controller. It is bound into every
// irq_ctrl8 instance.
// Assumes a synchronous active-low reset is asserted at time zero.
module irqc_checker #(
    parameter int N_IRQ = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             int_out,
    input logic             ack,
    input logic             wr_en,
    input logic             addr,
    input logic [7:0]       wdata,
    input logic             ready,
    input logic             aeoi,
    input logic [N_IRQ-1:0] irr,
    input logic [N_IRQ-1:0] mask,
    input logic [N_IRQ-1:0] isr
);
    // R2: no interrupt before initialization completes.
    a_r2_gated_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ready);

    // R4: the output implies an unmasked pending request.
    a_r4_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> |(irr & ~mask));

    // R7: a normal-mode acknowledge adds exactly one in-service bit.
    a_r7_isr_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_out && !aeoi && !wr_en)
        |=> ($countones(isr) == $countones($past(isr)) + 1));

    // R8: an automatic-mode acknowledge leaves in-service untouched.
    a_r8_aeoi_no_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_out && aeoi && !wr_en) |=> $stable(isr));

    // R9: end-of-service removes exactly one in-service bit.
    a_r9_eoi_clears_one: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && wr_en && !addr && (wdata[7:3] == 5'b00100) && !ack && (|isr))
        |=> ($countones(isr) + 1 == $countones($past(isr))));
endmodule

bind irq_ctrl8 irqc_checker #(.N_IRQ(N_IRQ)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .int_out (int_out),
    .ack     (ack),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .ready   (cfg_ready),
    .aeoi    (cfg_aeoi),
    .irr     (irr_q),
    .mask    (mask_q),
    .isr     (isr_q)
);

// File: tb/irq_ctrl8_bench.sv
module irq_ctrl8_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ack = 1'b0;
    logic [7:0] irq_in = '0;
    logic       int_out;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    irq_ctrl8 u_irq_ctrl8 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ack(ack), .irq_in(irq_in),
        .int_out(int_out)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic [7:0] mask;
        logic [7:0] irq;
        logic       hit;
        logic [7:0] vec;
    } vec_t;

    // Base 0x40, edge mode, normal end of service.
    localparam vec_t TBL [8] = '{
        '{8'h00, 8'h01, 1'b1, 8'h40},
        '{8'h00, 8'h80, 1'b1, 8'h47},
        '{8'h00, 8'h0C, 1'b1, 8'h42},
        '{8'h04, 8'h0C, 1'b1, 8'h43},
        '{8'hFF, 8'hFF, 1'b0, 8'h00},
        '{8'hF0, 8'hF0, 1'b0, 8'h00},
        '{8'h81, 8'h81, 1'b0, 8'h00},
        '{8'h01, 8'hA1, 1'b1, 8'h45}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        rd_en = 1'b0;
    endtask

    task automatic do_ack(output logic [7:0] v);
        @(negedge clk);
        ack = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    // Watchdog: a hang counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 check("R1 int after reset", {7'b0, int_out}, 8'h00);
        rd(1'b0, v); check("R1 read after reset", v, 8'h00);

        // R2: requests before initialization stay silent.
        set_irq(8'h01);
        check("R2 uninit gated", {7'b0, int_out}, 8'h00);
        set_irq(8'h00);

        // Table walk: masks and priorities.
        for (int k = 0; k < 8; k++) begin
            set_irq(8'h00);
            wr(1'b0, 8'h12);
            wr(1'b1, 8'h40);
            wr(1'b1, TBL[k].mask);
            set_irq(TBL[k].irq);
            check("R4 R5 table int", {7'b0, int_out}, {7'b0, TBL[k].hit});
            if (TBL[k].hit) begin
                do_ack(v);
                check("R3 R5 table vector", v, TBL[k].vec);
                wr(1'b0, 8'h20);
            end
        end
        set_irq(8'h00);

        // R2: cascaded sequence with third and fourth words.
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h50);
        set_irq(8'h04);
        check("R2 gated before third word", {7'b0, int_out}, 8'h00);
        wr(1'b1, 8'h00);
        check("R2 gated before fourth word", {7'b0, int_out}, 8'h00);
        wr(1'b1, 8'h01);
        check("R2 ready after fourth word", {7'b0, int_out}, 8'h01);
        do_ack(v); check("R3 cascade vector", v, 8'h52);
        wr(1'b0, 8'h20);
        set_irq(8'h00);
        check("R3 idle before spurious", {7'b0, int_out}, 8'h00);
        do_ack(v); check("R3 spurious vector", v, 8'h57);

        // Nesting: R5 R6 R7 R9 R10.
        wr(1'b0, 8'h12);
        wr(1'b1, 8'h40);
        set_irq(8'h08);
        do_ack(v); check("R7 first vector", v, 8'h43);
        wr(1'b0, 8'h0B);
        rd(1'b0, v); check("R7 R10 isr after ack", v, 8'h08);
        wr(1'b0, 8'h0A);
        rd(1'b0, v); check("R7 R10 irr after ack", v, 8'h00);
        set_irq(8'h28);
        check("R6 lower blocked", {7'b0, int_out}, 8'h00);
        set_irq(8'h2A);
        check("R6 higher preempts", {7'b0, int_out}, 8'h01);
        do_ack(v); check("R5 preempt vector", v, 8'h41);
        wr(1'b0, 8'h0B);
        rd(1'b0, v); check("R7 nested isr", v, 8'h0A);
        wr(1'b0, 8'h20);
        rd(1'b0, v); check("R9 first eoi", v, 8'h08);
        wr(1'b0, 8'h20);
        rd(1'b0, v); check("R9 second eoi", v, 8'h00);
        check("R6 pending released", {7'b0, int_out}, 8'h01);
        do_ack(v); check("R5 released vector", v, 8'h45);
        wr(1'b0, 8'h20);

        // R11: held inputs do not relatch.
        check("R11 held no relatch", {7'b0, int_out}, 8'h00);
        wr(1'b0, 8'h0A);
        rd(1'b0, v); check("R11 irr held", v, 8'h00);
        set_irq(8'h00);
        set_irq(8'h02);
        check("R11 new edge", {7'b0, int_out}, 8'h01);
        do_ack(v);
        wr(1'b0, 8'h20);
        set_irq(8'h00);

        // R4 mask readback, then R13 restart.
        wr(1'b1, 8'h5A);
        rd(1'b1, v); check("R4 mask read", v, 8'h5A);
        wr(1'b0, 8'h12);
        rd(1'b1, v); check("R13 mask cleared", v, 8'h00);
        set_irq(8'h01);
        check("R13 gated during restart", {7'b0, int_out}, 8'h00);
        wr(1'b1, 8'h60);
        check("R13 ready after base", {7'b0, int_out}, 8'h01);
        do_ack(v); check("R13 new base vector", v, 8'h60);
        wr(1'b0, 8'h20);
        set_irq(8'h00);

        // R8: automatic end of service.
        wr(1'b0, 8'h13);
        wr(1'b1, 8'h40);
        wr(1'b1, 8'h03);
        set_irq(8'h01);
        do_ack(v); check("R8 vector", v, 8'h40);
        wr(1'b0, 8'h0B);
        rd(1'b0, v); check("R8 isr stays clear", v, 8'h00);
        set_irq(8'h00);

        // R12: level mode follows the input.
        wr(1'b0, 8'h1A);
        wr(1'b1, 8'h40);
        set_irq(8'h10);
        check("R12 level high", {7'b0, int_out}, 8'h01);
        rd(1'b0, v); check("R12 irr follows", v, 8'h10);
        set_irq(8'h00);
        check("R12 level drop", {7'b0, int_out}, 8'h00);
        rd(1'b0, v); check("R12 irr cleared", v, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule